// File: doc/BRIEF.md
# Trigger Latency Pipeline with Event Buffer

This block sits behind a bank of digitizers that deliver one 12-bit sample per channel on every sample clock. Samples arrive at six times the beam-crossing rate. The block writes the whole row of channel samples into a circular delay line on every cycle. When a level-1 accept strobe arrives, the block reserves one of eight event slots. It records where in the delay line the triggering window begins, which is the current write position minus the programmed latency. A capture engine then copies twelve consecutive rows from that point into the slot. Accepts that arrive while an earlier capture is still running wait in line behind it and are not lost.

A readout port with a valid/ready handshake drains completed slots strictly in the order they were accepted. Each event leaves the port as one header word carrying a running event number, followed by all twelve samples of channel 0, then all twelve of channel 1, and so on. When all eight slots are held, the block refuses any further accept. It raises a sticky overflow flag and counts the refusals, and the events already stored are left untouched.

Top module: `trig_latency_buffer`

## Requirements
- R1: After a synchronous active-low reset, `evt_valid`, `queue_full` and `overflow_seen` are 0, and `overflow_count` and `accept_count` are 0.
- R2: For an accept seen at clock edge E with `trig_delay` = D (legal range 12..240), the captured window is the 12 sample rows written at edges E−D through E−D+11, in that order. The row written at edge E is the one on `adc_samples` at E.
- R3: A header word is `{1'b1, 3'b000, event_number[11:0]}`. The event number is the value of `accept_count` before the accept that created the event, so the first accepted event is number 0.
- R4: After its header, an event carries N_CH×12 sample words, each `{4'b0000, sample[11:0]}`. They are ordered channel-major: sample index 0..11 of channel 0, then of channel 1, and so on. Channel c is `adc_samples[12c +: 12]`. `evt_last` is high on the final sample word only.
- R5: Events leave the read port in the order their accepts were taken.
- R6: An accept that arrives while earlier captures are pending or running is still taken, provided a slot is free. Accepts on edges two cycles apart are all delivered.
- R7: While eight events are held, `queue_full` is 1 and an accept is refused. `overflow_seen` becomes 1 and stays 1 until reset. `overflow_count` increments (saturating at 255), and the held events are delivered intact.
- R8: While `evt_valid` is 1 and `evt_ready` is 0, `evt_valid` stays 1 and `evt_data` holds its value. A word is transferred on an edge where both are 1.
- R9: `accept_count` increments by exactly one for each taken accept and is unchanged by a refused accept or by no accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_samples | input | 48 | One 12-bit sample per channel, channel c at bits 12c+11..12c |
| l1_accept | input | 1 | Level-1 accept strobe, one cycle per accept |
| trig_delay | input | 8 | Trigger latency in samples, sampled on the accept edge |
| evt_ready | input | 1 | Downstream can take a word |
| evt_valid | output | 1 | A word is offered on `evt_data` |
| evt_data | output | 16 | Header or sample word |
| evt_last | output | 1 | Final word of the current event |
| queue_full | output | 1 | All event slots are held |
| overflow_seen | output | 1 | Sticky: an accept was refused |
| overflow_count | output | 8 | Number of refused accepts, saturating |
| accept_count | output | 16 | Number of taken accepts |

## Verification
The status outputs `queue_full`, `overflow_seen`, `overflow_count` and `accept_count` change on the same edge that takes or refuses the accept. The bench drives each accept just after a rising edge and reads the flags at the next falling edge. An event taken on an idle block becomes readable after 14 edges: one to start the capture, twelve delay-line reads, and one trailing slot write. The bench therefore never waits on a fixed count for data. It compares every word at the falling edge that precedes the transfer edge, against a model queue built at accept time from the tick number, the delay and the channel index. `evt_data` follows the read state combinationally, so a held word is compared on every stalled falling edge.

// File: rtl/trig_latency_pkg.sv
// Shared constants and word builders for the trigger latency pipeline.
// Assumes 12-bit samples and a 16-bit read word.
package trig_latency_pkg;
    localparam int SAMPLE_W = 12;
    localparam int EVN_W    = 12;
    localparam int OUT_W    = 16;

    // Header word: marker bit, three zero bits, event number.
    function automatic logic [OUT_W-1:0] hdr_word(input logic [EVN_W-1:0] evn);
        return {1'b1, 3'b000, evn};
    endfunction

    // Sample word: four zero bits, sample value.
    function automatic logic [OUT_W-1:0] smp_word(input logic [SAMPLE_W-1:0] s);
        return {4'b0000, s};
    endfunction
endpackage

// File: rtl/trig_latency_ring.sv
// Circular delay line: one full row of channel samples is written per clock.
// The write pointer advances every cycle and wraps naturally.
// There is one registered read port, whose data appears one cycle after the address.
// Assumes DEPTH is a power of two.
module trig_latency_ring #(
    parameter int DEPTH = 512,
    parameter int ROW_W = 48,
    localparam int RA_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] wr_row,
    input  logic [RA_W-1:0]  rd_addr,
    output logic [ROW_W-1:0] rd_row,
    output logic [RA_W-1:0]  wr_ptr
);
    logic [ROW_W-1:0] mem [DEPTH];

    // Advance the write position once per sample clock.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_ptr <= '0;
        else        wr_ptr <= wr_ptr + 1'b1;
    end

    // Store the incoming row and serve the registered read.
    always_ff @(posedge clk) begin
        mem[wr_ptr] <= wr_row;
        rd_row      <= mem[rd_addr];
    end
endmodule

// File: rtl/trig_latency_capture.sv
// Capture engine: walks allocated slots in order and reads WIN_LEN rows
// from the delay line starting at each slot's recorded start address.
// Every row is written into the slot one cycle after its read is issued.
// done_ptr advances once a slot's last row has been written.
module trig_latency_capture #(
    parameter int WIN_LEN = 12,
    parameter int N_SLOT  = 8,
    parameter int RA_W    = 9,
    localparam int SL_W   = $clog2(N_SLOT),
    localparam int WI_W   = $clog2(WIN_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SL_W:0]   alloc_ptr,
    input  logic [RA_W-1:0] start_addr,
    output logic [SL_W-1:0] iss_slot,
    output logic [RA_W-1:0] ring_raddr,
    output logic            wr_en,
    output logic [SL_W-1:0] wr_slot,
    output logic [WI_W-1:0] wr_row,
    output logic [SL_W:0]   done_ptr
);
    logic [SL_W:0]   iss_ptr;
    logic            busy;
    logic [WI_W-1:0] k;
    logic            wr_last;
    logic            k_end;

    assign k_end      = (k == WI_W'(WIN_LEN - 1));
    assign iss_slot   = iss_ptr[SL_W-1:0];
    assign ring_raddr = start_addr + RA_W'(k);

    // Issue side: start on a pending slot, then step through the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_ptr <= '0;
            busy    <= 1'b0;
            k       <= '0;
        end else if (busy) begin
            if (k_end) begin
                busy    <= 1'b0;
                k       <= '0;
                iss_ptr <= iss_ptr + 1'b1;
            end else begin
                k <= k + 1'b1;
            end
        end else if (iss_ptr != alloc_ptr) begin
            busy <= 1'b1;
            k    <= '0;
        end
    end

    // Write side: follow the read latency by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en    <= 1'b0;
            wr_last  <= 1'b0;
            wr_slot  <= '0;
            wr_row   <= '0;
            done_ptr <= '0;
        end else begin
            wr_en   <= busy;
            wr_last <= busy && k_end;
            wr_slot <= iss_slot;
            wr_row  <= k;
            if (wr_en && wr_last) done_ptr <= done_ptr + 1'b1;
        end
    end
endmodule

// File: rtl/trig_latency_readout.sv
// Readout sequencer: for each completed slot, in order, offers a header
// and then N_CH*WIN_LEN sample words, channel-major, on a valid/ready port.
// Word data is combinational from the sequencer state, so it holds under stall.
module trig_latency_readout
    import trig_latency_pkg::*;
#(
    parameter int N_CH    = 4,
    parameter int WIN_LEN = 12,
    parameter int N_SLOT  = 8,
    localparam int SL_W   = $clog2(N_SLOT),
    localparam int WI_W   = $clog2(WIN_LEN),
    localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
    localparam int ROW_W  = N_CH * SAMPLE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SL_W:0]    done_ptr,
    input  logic [ROW_W-1:0] row_data,
    input  logic [EVN_W-1:0] evn,
    input  logic             ready,
    output logic [SL_W-1:0]  rd_slot,
    output logic [WI_W-1:0]  rd_row,
    output logic             valid,
    output logic [OUT_W-1:0] data,
    output logic             last,
    output logic [SL_W:0]    rd_ptr
);
    logic            hdr;
    logic [CH_W-1:0] ch;
    logic            s_end;
    logic            ch_end;

    assign valid   = (rd_ptr != done_ptr);
    assign rd_slot = rd_ptr[SL_W-1:0];
    assign s_end   = (rd_row == WI_W'(WIN_LEN - 1));
    assign ch_end  = (ch == CH_W'(N_CH - 1));
    assign last    = valid && !hdr && s_end && ch_end;
    assign data    = hdr ? hdr_word(evn) : smp_word(row_data[ch*SAMPLE_W +: SAMPLE_W]);

    // Step header -> samples -> next channel -> next event on each transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            hdr    <= 1'b1;
            ch     <= '0;
            rd_row <= '0;
        end else if (valid && ready) begin
            if (hdr) begin
                hdr    <= 1'b0;
                ch     <= '0;
                rd_row <= '0;
            end else if (s_end) begin
                rd_row <= '0;
                if (ch_end) begin
                    hdr    <= 1'b1;
                    rd_ptr <= rd_ptr + 1'b1;
                end else begin
                    ch <= ch + 1'b1;
                end
            end else begin
                rd_row <= rd_row + 1'b1;
            end
        end
    end
endmodule

// File: rtl/trig_latency_buffer.sv
// Top: delay line, slot allocation on level-1 accept, capture engine,
// slot storage and ordered readout. Refuses accepts when all slots are held.
// Assumes trig_delay stays within WIN_LEN..MAX_DELAY and RING_DEPTH is a
// power of two large enough for the maximum delay plus the capture backlog.
module trig_latency_buffer
    import trig_latency_pkg::*;
#(
    parameter int N_CH       = 4,
    parameter int WIN_LEN    = 12,
    parameter int N_SLOT     = 8,
    parameter int MAX_DELAY  = 240,
    parameter int RING_DEPTH = 512,
    localparam int ROW_W  = N_CH * SAMPLE_W,
    localparam int RA_W   = $clog2(RING_DEPTH),
    localparam int SL_W   = $clog2(N_SLOT),
    localparam int PTR_W  = SL_W + 1,
    localparam int WI_W   = $clog2(WIN_LEN),
    localparam int SM_N   = N_SLOT * WIN_LEN,
    localparam int SM_W   = $clog2(SM_N),
    localparam int DLY_W  = $clog2(MAX_DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ROW_W-1:0] adc_samples,
    input  logic             l1_accept,
    input  logic [DLY_W-1:0] trig_delay,
    input  logic             evt_ready,
    output logic             evt_valid,
    output logic [OUT_W-1:0] evt_data,
    output logic             evt_last,
    output logic             queue_full,
    output logic             overflow_seen,
    output logic [7:0]       overflow_count,
    output logic [15:0]      accept_count
);
    logic [RA_W-1:0]  wr_ptr, ring_raddr, start_addr;
    logic [ROW_W-1:0] ring_q, rd_row_data;
    logic [PTR_W-1:0] alloc_ptr, done_ptr, rd_ptr, occ;
    logic [SL_W-1:0]  iss_slot, wr_slot, rd_slot;
    logic [WI_W-1:0]  wr_row, rd_row;
    logic             wr_en, accept_ok;

    logic [RA_W-1:0]  slot_start [N_SLOT];
    logic [EVN_W-1:0] slot_evn   [N_SLOT];
    logic [ROW_W-1:0] slot_mem   [SM_N];

    assign occ        = alloc_ptr - rd_ptr;
    assign queue_full = (occ == PTR_W'(N_SLOT));
    assign accept_ok  = l1_accept && !queue_full;
    assign start_addr = slot_start[iss_slot];
    assign rd_row_data = slot_mem[SM_W'(rd_slot) * SM_W'(WIN_LEN) + SM_W'(rd_row)];

    trig_latency_ring #(.DEPTH(RING_DEPTH), .ROW_W(ROW_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .wr_row(adc_samples),
        .rd_addr(ring_raddr), .rd_row(ring_q), .wr_ptr(wr_ptr)
    );

    trig_latency_capture #(.WIN_LEN(WIN_LEN), .N_SLOT(N_SLOT), .RA_W(RA_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .alloc_ptr(alloc_ptr), .start_addr(start_addr),
        .iss_slot(iss_slot), .ring_raddr(ring_raddr), .wr_en(wr_en),
        .wr_slot(wr_slot), .wr_row(wr_row), .done_ptr(done_ptr)
    );

    trig_latency_readout #(.N_CH(N_CH), .WIN_LEN(WIN_LEN), .N_SLOT(N_SLOT)) u_rd (
        .clk(clk), .rst_n(rst_n), .done_ptr(done_ptr), .row_data(rd_row_data),
        .evn(slot_evn[rd_slot]), .ready(evt_ready), .rd_slot(rd_slot),
        .rd_row(rd_row), .valid(evt_valid), .data(evt_data), .last(evt_last),
        .rd_ptr(rd_ptr)
    );

    // Record the window start and event number of a newly taken accept.
    always_ff @(posedge clk) begin
        if (accept_ok) begin
            slot_start[alloc_ptr[SL_W-1:0]] <= wr_ptr - RA_W'(trig_delay);
            slot_evn[alloc_ptr[SL_W-1:0]]   <= accept_count[EVN_W-1:0];
        end
    end

    // Store captured rows into their slot.
    always_ff @(posedge clk) begin
        if (wr_en) slot_mem[SM_W'(wr_slot) * SM_W'(WIN_LEN) + SM_W'(wr_row)] <= ring_q;
    end

    // Allocation pointer, accept counter and overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alloc_ptr      <= '0;
            accept_count   <= '0;
            overflow_seen  <= 1'b0;
            overflow_count <= '0;
        end else if (accept_ok) begin
            alloc_ptr    <= alloc_ptr + 1'b1;
            accept_count <= accept_count + 16'd1;
        end else if (l1_accept) begin
            overflow_seen <= 1'b1;
            if (overflow_count != 8'hFF) overflow_count <= overflow_count + 8'd1;
        end
    end
endmodule

// File: rtl/trig_latency_buffer_chk.sv
// Checker for trig_latency_buffer, bound to every instance of the top.
// Observes ports only; assumes the synchronous active-low reset.
module trig_latency_buffer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        l1_accept,
    input logic        evt_ready,
    input logic        evt_valid,
    input logic [15:0] evt_data,
    input logic        evt_last,
    input logic        queue_full,
    input logic        overflow_seen,
    input logic [7:0]  overflow_count,
    input logic [15:0] accept_count
);
    logic after_rst = 1'b0;

    // Remember that the previous edge was in reset.
    always_ff @(posedge clk) after_rst <= !rst_n;

    // Outputs are cleared on the cycle after reset.
    always @(posedge clk) begin
        if (rst_n && after_rst)
            assert_reset_state_R1: assert (!evt_valid && !queue_full && !overflow_seen
                                           && overflow_count == 8'd0 && accept_count == 16'd0);
    end

    assert_hdr_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_ready && evt_last |=> !evt_valid || evt_data[15]);

    assert_last_is_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_last |-> !evt_data[15]);

    assert_refuse_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        queue_full && l1_accept |=> overflow_seen && overflow_count != 8'd0 && $stable(accept_count));

    assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_seen |=> overflow_seen);

    assert_hold_under_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_ready |=> evt_valid && $stable(evt_data));

    assert_count_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !l1_accept |=> $stable(accept_count));

    assert_count_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        l1_accept && !queue_full |=> accept_count == $past(accept_count) + 16'd1);
endmodule

bind trig_latency_buffer trig_latency_buffer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .l1_accept(l1_accept), .evt_ready(evt_ready),
    .evt_valid(evt_valid), .evt_data(evt_data), .evt_last(evt_last),
    .queue_full(queue_full), .overflow_seen(overflow_seen),
    .overflow_count(overflow_count), .accept_count(accept_count)
);

// File: tb/trig_latency_buffer_tb.sv
`timescale 1ns/1ps
module trig_latency_buffer_tb;
    localparam int N_CH = 4;
    localparam int WIN  = 12;
    localparam int NV   = 6;
    localparam int TBL_D [NV] = '{12, 240, 100, 37, 200, 12};
    localparam int TBL_G [NV] = '{20, 1, 1, 3, 30, 5};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N_CH*12-1:0] adc_samples = '0;
    logic l1_accept = 1'b0;
    logic [7:0] trig_delay = 8'd12;
    logic evt_ready = 1'b0;
    logic evt_valid, evt_last, queue_full, overflow_seen;
    logic [15:0] evt_data, accept_count;
    logic [7:0] overflow_count;

    int n_chk = 0, n_err = 0, tick = 0;
    int q_ta [64], q_d [64], q_evn [64];
    int q_head = 0, q_tail = 0, next_evn = 0, mon_pos = 0;
    bit done = 1'b0;
    bit stalled = 1'b0;
    logic [15:0] stall_word = '0;

    trig_latency_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .adc_samples(adc_samples), .l1_accept(l1_accept),
        .trig_delay(trig_delay), .evt_ready(evt_ready), .evt_valid(evt_valid),
        .evt_data(evt_data), .evt_last(evt_last), .queue_full(queue_full),
        .overflow_seen(overflow_seen), .overflow_count(overflow_count),
        .accept_count(accept_count)
    );

    always #2 clk = ~clk;

    function automatic logic [11:0] smp(input int t, input int c);
        return 12'((t * 5 + c * 97 + 3) & 4095);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample source: a new row every cycle, tagged by tick.
    always @(posedge clk) begin
        #0.5;
        tick = tick + 1;
        for (int c = 0; c < N_CH; c++) adc_samples[c*12 +: 12] = smp(tick, c);
    end

    // Read-port monitor: compares each transferred word to the model (R2 R3 R4 R5),
    // and the held word under stall (R8).
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled && evt_valid)
                chk(evt_data == stall_word, "R8 stall hold", evt_data, stall_word);
            stalled = evt_valid && !evt_ready;
            stall_word = evt_data;
            if (evt_valid && evt_ready) begin
                if (q_head == q_tail) begin
                    chk(1'b0, "R5 unexpected word", evt_data, 0);
                end else if (mon_pos == 0) begin
                    chk(evt_data == {4'h8, 12'(q_evn[q_head % 64])}, "R3/R5 header",
                        evt_data, {4'h8, 12'(q_evn[q_head % 64])});
                    mon_pos = 1;
                end else begin
                    int c, s;
                    logic [15:0] e;
                    c = (mon_pos - 1) / WIN;
                    s = (mon_pos - 1) % WIN;
                    e = {4'h0, smp(q_ta[q_head % 64] - q_d[q_head % 64] + s, c)};
                    chk(evt_data == e, "R2/R4 sample", evt_data, e);
                    chk(evt_last == (mon_pos == N_CH * WIN), "R4 last flag", evt_last,
                        mon_pos == N_CH * WIN);
                    if (mon_pos == N_CH * WIN) begin
                        mon_pos = 0;
                        q_head++;
                    end else mon_pos++;
                end
            end
        end
    end

    // One accept pulse, then gap idle cycles.
    task automatic pulse(input int d, input int gap, input bit take);
        @(posedge clk); #1;
        trig_delay = 8'(d);
        l1_accept = 1'b1;
        if (take) begin
            q_ta[q_tail % 64] = tick;
            q_d[q_tail % 64] = d;
            q_evn[q_tail % 64] = next_evn;
            q_tail++;
            next_evn++;
        end
        @(posedge clk); #1;
        l1_accept = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic drain(input bit toggle);
        for (int i = 0; i < 5000 && (q_head != q_tail); i++) begin
            @(posedge clk); #1;
            evt_ready = toggle ? ~evt_ready : 1'b1;
        end
        @(posedge clk); #1;
        evt_ready = 1'b1;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!evt_valid, "R1 evt_valid", evt_valid, 0);
        chk(!queue_full, "R1 queue_full", queue_full, 0);
        chk(!overflow_seen, "R1 overflow_seen", overflow_seen, 0);
        chk(overflow_count == 0, "R1 overflow_count", overflow_count, 0);
        chk(accept_count == 0, "R1 accept_count", accept_count, 0);
        repeat (300) @(posedge clk);

        // Table walk: delays and spacings, accepts queued during capture (R6).
        #1 evt_ready = 1'b1;
        for (int v = 0; v < NV; v++) pulse(TBL_D[v], TBL_G[v], 1'b1);
        drain(1'b0);
        @(negedge clk);
        chk(accept_count == NV, "R6/R9 all accepts taken", accept_count, NV);
        chk(q_head == q_tail, "R6 all events delivered", q_tail - q_head, 0);

        // Overflow: fill all eight slots with readout held off (R7).
        @(posedge clk); #1 evt_ready = 1'b0;
        for (int i = 0; i < 8; i++) pulse(20 + 10 * i, 1, 1'b1);
        repeat (120) @(posedge clk);
        @(negedge clk);
        chk(queue_full, "R7 full after eight", queue_full, 1);
        chk(!overflow_seen, "R7 no overflow yet", overflow_seen, 0);
        pulse(50, 0, 1'b0);
        @(negedge clk);
        chk(overflow_seen, "R7 overflow flag", overflow_seen, 1);
        chk(overflow_count == 1, "R7 overflow count", overflow_count, 1);
        chk(accept_count == NV + 8, "R9 refused not counted", accept_count, NV + 8);
        pulse(60, 0, 1'b0);
        @(negedge clk);
        chk(overflow_count == 2, "R7 overflow count 2", overflow_count, 2);

        // Drain with alternating ready; stored events must be intact (R7 R8).
        drain(1'b1);
        @(negedge clk);
        chk(!queue_full, "R7 full clears after drain", queue_full, 0);
        chk(overflow_seen, "R7 flag sticky", overflow_seen, 1);

        // One more accept after overflow gets the next event number (R3 R9).
        pulse(12, 0, 1'b1);
        drain(1'b0);
        @(negedge clk);
        chk(accept_count == NV + 9, "R9 final count", accept_count, NV + 9);
        chk(q_head == q_tail && !evt_valid, "R5 queue empty at end", evt_valid, 0);
        finish_run();
    end
endmodule